// File: doc/BRIEF.md
# Fixed-Point 8x8 Block Cosine Transform Engine

This block is a coprocessor that sits on a processor's memory bus. It computes the two-dimensional discrete cosine transform of an 8x8 block of signed 8-bit samples, using integer fixed-point arithmetic only. Software first pushes the 64 samples one byte at a time into a data-in register. It then writes 1 to a command register and polls a status register until the result is ready. Finally it pops the 64 transformed bytes from a data-out register.

The engine has one multiplier, which it reuses for every term. It first transforms each row of the block into a 16-bit intermediate buffer, then transforms each column of that buffer into the output buffer. Each output element takes eight multiply-accumulate steps. The cosine coefficients are signed 8-bit values with six fractional bits. Every product is scaled back with an arithmetic shift right by six before it is added to the accumulator.

Top module: `dct8_coproc`

## Requirements
- R1: `reg_sel` selects the register: 0 is data-in, 1 is data-out, 2 is command and 3 is status. A read of data-in or command returns 0. Read data appears on `rd_data` in the cycle after `rd_en` is sampled, and `rd_data` is 0 in every cycle that does not follow a read.
- R2: While idle, a write to data-in stores the byte at the next sample index, which is row*8+column (row-major order). The index wraps from 63 to 0, so a 65th push overwrites sample 0.
- R3: While idle, writing exactly 1 to the command register starts a transform and resets both the push index and the pop index to 0. A command write of any other value changes nothing.
- R4: A status read returns 1 in bit 0 when idle and 0 while busy; bits 7:1 always read 0. The unit is busy for exactly 1025 cycles after a start.
- R5: The coefficient for frequency u and position x is 23 when u is 0. For u from 1 to 7 it is 32*cos((2x+1)*u*pi/16) rounded to the nearest integer. Both are signed values with 6 fractional bits.
- R6: Row pass: T[r][u] = sum over x of (C(u,x)*f[r][x]) >>> 6. Column pass: F[v][u] = sum over y of (C(v,y)*T[y][u]) >>> 6. The shift is arithmetic (floor), and the sums are plain integer adds.
- R7: Samples are two's complement. Each output is saturated to the range -128 to 127 before it is stored.
- R8: Data-out pops F in index order v*8+u, and the pop index wraps from 63 to 0.
- R9: While busy, pushes and command writes are ignored. A data-out read returns 0 and does not advance the pop index.
- R10: A new start without reloading recomputes the same results from the retained input block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select for the current access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |

## Verification
Every read result is due exactly one clock after the edge that samples `rd_en`. The bench drives strobes on falling edges and samples `rd_data` on the next falling edge. On every other falling edge it checks that `rd_data` is 0. After a start, the status reads back-to-back are counted. The bench first sees ready on the 1026th poll, because the unit is busy for 1025 cycles and the status register adds one more. The bench checks that count within a narrow window, and a counter in the checker checks the exact busy length. Output values are compared against a behavioural model of the two passes, built from a cosine table the bench computes itself.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
  localparam int BLK_N   = 8;
  localparam int BLK_LOG = 3;
  localparam int BLK_SZ  = BLK_N * BLK_N;
  localparam int IDX_W   = 2 * BLK_LOG;
  localparam int STEPS   = 2 * BLK_SZ * BLK_N;   // two passes, N MACs per element
  localparam int BUSY_CYCLES = STEPS + 1;        // plus one drain stage

  typedef enum logic [1:0] {
    SEL_DIN  = 2'd0,
    SEL_DOUT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  // R5: cosine weight with 6 fractional bits, folded over one period of 32
  function automatic logic signed [7:0] dct_coef(input logic [2:0] u, input logic [2:0] x);
    int ph, fold, sgn, mag;
    if (u == 3'd0) return 8'sd23;
    ph = ((2 * int'(x) + 1) * int'(u)) % 32;
    if (ph <= 8)       begin fold = ph;      sgn = 1;  end
    else if (ph <= 16) begin fold = 16 - ph; sgn = -1; end
    else if (ph <= 24) begin fold = ph - 16; sgn = -1; end
    else               begin fold = 32 - ph; sgn = 1;  end
    case (fold)
      0: mag = 32;
      1: mag = 31;
      2: mag = 30;
      3: mag = 27;
      4: mag = 23;
      5: mag = 18;
      6: mag = 12;
      7: mag = 6;
      default: mag = 0;
    endcase
    return 8'(sgn * mag);
  endfunction
endpackage

// File: rtl/dct8_ram.sv
module dct8_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dct8_coef_rom.sv
module dct8_coef_rom #(
  parameter int COEF_W = 8
) (
  input  logic                     clk,
  input  logic [2:0]               freq,
  input  logic [2:0]               pos,
  output logic signed [COEF_W-1:0] coef_q
);
  import dct8_pkg::*;

  always_ff @(posedge clk) begin
    coef_q <= COEF_W'(dct_coef(freq, pos));
  end
endmodule

// File: rtl/dct8_seq.sv
module dct8_seq
  import dct8_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] in_raddr,
  output logic [IDX_W-1:0] tmp_raddr,
  output logic [2:0]       coef_freq,
  output logic [2:0]       coef_pos,
  output logic             s_vld,
  output logic             s_pass,
  output logic             s_first,
  output logic             s_last,
  output logic [IDX_W-1:0] s_elem
);
  localparam int CW = $clog2(STEPS);

  logic [CW-1:0]      step;
  logic               running;
  logic               pass;
  logic [IDX_W-1:0]   elem;
  logic [BLK_LOG-1:0] k;

  assign pass = step[CW-1];
  assign elem = step[BLK_LOG+IDX_W-1:BLK_LOG];
  assign k    = step[BLK_LOG-1:0];

  // row pass: element (r,u) reads in[r][k]; column pass: (v,u) reads tmp[k][u]
  assign in_raddr  = {elem[IDX_W-1:BLK_LOG], k};
  assign tmp_raddr = {k, elem[BLK_LOG-1:0]};
  assign coef_freq = pass ? elem[IDX_W-1:BLK_LOG] : elem[BLK_LOG-1:0];
  assign coef_pos  = k;
  assign busy      = running | s_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      step    <= '0;
      s_vld   <= 1'b0;
      s_pass  <= 1'b0;
      s_first <= 1'b0;
      s_last  <= 1'b0;
      s_elem  <= '0;
    end else begin
      s_vld   <= running;
      s_pass  <= pass;
      s_first <= (k == '0);
      s_last  <= (k == '1);
      s_elem  <= elem;
      if (start) begin
        running <= 1'b1;
        step    <= '0;
      end else if (running) begin
        step <= step + 1'b1;
        if (step == CW'(STEPS - 1)) running <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dct8_mac.sv
module dct8_mac #(
  parameter int COEF_W = 8,
  parameter int ACC_W  = 16,
  parameter int FRAC_W = 6,
  parameter int OUT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld,
  input  logic                     first,
  input  logic                     last,
  input  logic                     pass,
  input  logic signed [COEF_W-1:0] coef,
  input  logic signed [ACC_W-1:0]  opnd,
  output logic                     tmp_we,
  output logic [ACC_W-1:0]         tmp_wdata,
  output logic                     out_we,
  output logic [OUT_W-1:0]         out_wdata
);
  localparam int PROD_W = COEF_W + ACC_W;
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = ~OUT_MAX;

  logic signed [PROD_W-1:0] coef_x, opnd_x, prod, scaled;
  logic signed [ACC_W-1:0]  acc, acc_next;

  always_comb begin
    coef_x   = PROD_W'(coef);
    opnd_x   = PROD_W'(opnd);
    prod     = coef_x * opnd_x;
    scaled   = prod >>> FRAC_W;                          // R6
    acc_next = (first ? '0 : acc) + ACC_W'(scaled);
  end

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (vld) acc <= acc_next;
  end

  assign tmp_we    = vld && last && !pass;
  assign out_we    = vld && last && pass;
  assign tmp_wdata = acc_next;

  always_comb begin                                      // R7
    if (acc_next > OUT_MAX)      out_wdata = OUT_W'(OUT_MAX);
    else if (acc_next < OUT_MIN) out_wdata = OUT_W'(OUT_MIN);
    else                         out_wdata = OUT_W'(acc_next);
  end
endmodule

// File: rtl/dct8_coproc.sv
module dct8_coproc #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int FRAC_W = 6,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  import dct8_pkg::*;

  logic                     busy, start, push, pop;
  logic [IDX_W-1:0]         push_ptr, pop_ptr, pop_next;
  logic [IDX_W-1:0]         in_raddr, tmp_raddr, s_elem;
  logic [2:0]               coef_freq, coef_pos;
  logic                     s_vld, s_pass, s_first, s_last;
  logic [DATA_W-1:0]        in_rdata, out_rdata, out_wdata;
  logic [ACC_W-1:0]         tmp_rdata, tmp_wdata;
  logic                     tmp_we, out_we;
  logic signed [COEF_W-1:0] coef_q;
  logic signed [ACC_W-1:0]  opnd;

  // R2 R3 R9: bus side effects only while idle
  assign push  = wr_en && (reg_sel == SEL_DIN) && !busy;
  assign start = wr_en && (reg_sel == SEL_CMD) && (wr_data == DATA_W'(1)) && !busy;
  assign pop   = rd_en && (reg_sel == SEL_DOUT) && !busy;

  assign pop_next = start ? '0 : (pop ? pop_ptr + 1'b1 : pop_ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      push_ptr <= '0;
      pop_ptr  <= '0;
    end else begin
      pop_ptr <= pop_next;
      if (start)     push_ptr <= '0;
      else if (push) push_ptr <= push_ptr + 1'b1;
    end
  end

  dct8_seq u_seq (
    .clk, .rst, .start, .busy,
    .in_raddr, .tmp_raddr, .coef_freq, .coef_pos,
    .s_vld, .s_pass, .s_first, .s_last, .s_elem
  );

  dct8_ram #(.W(DATA_W), .DEPTH(BLK_SZ)) u_in_buf (
    .clk, .we(push), .waddr(push_ptr), .wdata(wr_data),
    .raddr(in_raddr), .rdata(in_rdata)
  );

  dct8_ram #(.W(ACC_W), .DEPTH(BLK_SZ)) u_tmp_buf (
    .clk, .we(tmp_we), .waddr(s_elem), .wdata(tmp_wdata),
    .raddr(tmp_raddr), .rdata(tmp_rdata)
  );

  dct8_ram #(.W(DATA_W), .DEPTH(BLK_SZ)) u_out_buf (
    .clk, .we(out_we), .waddr(s_elem), .wdata(out_wdata),
    .raddr(pop_next), .rdata(out_rdata)
  );

  dct8_coef_rom #(.COEF_W(COEF_W)) u_rom (
    .clk, .freq(coef_freq), .pos(coef_pos), .coef_q
  );

  assign opnd = s_pass ? $signed(tmp_rdata) : ACC_W'($signed(in_rdata));

  dct8_mac #(.COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W), .OUT_W(DATA_W)) u_mac (
    .clk, .rst, .vld(s_vld), .first(s_first), .last(s_last), .pass(s_pass),
    .coef(coef_q), .opnd, .tmp_we, .tmp_wdata, .out_we, .out_wdata
  );

  // R1 R4 R8: registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (reg_sel)
        SEL_DOUT: rd_data <= busy ? '0 : out_rdata;
        SEL_STAT: rd_data <= DATA_W'(!busy);
        default:  rd_data <= '0;
      endcase
    end else begin
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/dct8_coproc_chk.sv
module dct8_coproc_chk
  import dct8_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [1:0]       reg_sel,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             rd_en,
  input logic [7:0]       rd_data,
  input logic             busy,
  input logic [IDX_W-1:0] push_ptr,
  input logic [IDX_W-1:0] pop_ptr
);
  localparam int BCW = $clog2(BUSY_CYCLES + 2);
  logic [BCW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd2 && wr_data == 8'd1 && !busy) |=> busy); // R3
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_cnt == BCW'(BUSY_CYCLES)); // R4
  AST_BUSY_CAP: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_cnt < BCW'(BUSY_CYCLES)); // R4
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && reg_sel == 2'd0) |=> $stable(push_ptr)); // R9
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    (!busy && rd_en && reg_sel == 2'd1) |=> pop_ptr == $past(pop_ptr) + 1'b1); // R8
  AST_BUSY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_en && reg_sel == 2'd1) |=> (rd_data == 8'd0 && $stable(pop_ptr))); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == 8'd0); // R1
endmodule

bind dct8_coproc dct8_coproc_chk u_chk (.*);

// File: tb/dct8_coproc_tb.sv
`timescale 1ns/1ps
module dct8_coproc_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;

  int nchk = 0, nerr = 0;
  bit done = 0;
  int cf [8][8];
  int blk [64];
  int exp_o [64];
  logic prev_rd = 1'b0;

  always #4 clk = ~clk;

  dct8_coproc u_dut (.clk, .rst, .reg_sel, .wr_en, .wr_data, .rd_en, .rd_data);

  task automatic chk(input string req, input int act, input int expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // every clock: no read sampled at the last edge means rd_data is 0 (R1)
  always @(posedge clk) prev_rd <= rd_en;
  always @(negedge clk) if (!rst && !prev_rd && !done) chk("R1 idle rd_data", int'(rd_data), 0);

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int sat8(input int v);
    return (v > 127) ? 127 : ((v < -128) ? -128 : v);
  endfunction

  task automatic model();
    int t [64];
    for (int r = 0; r < 8; r++)
      for (int u = 0; u < 8; u++) begin
        int s = 0;
        for (int x = 0; x < 8; x++) s += (cf[u][x] * blk[r*8+x]) >>> 6;
        t[r*8+u] = s;
      end
    for (int v = 0; v < 8; v++)
      for (int u = 0; u < 8; u++) begin
        int s = 0;
        for (int y = 0; y < 8; y++) s += (cf[v][y] * t[y*8+u]) >>> 6;
        exp_o[v*8+u] = sat8(s);
      end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] sel, output int d);
    reg_sel = sel; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = int'($signed(rd_data));
  endtask

  task automatic load_block();
    for (int i = 0; i < 64; i++) bus_write(2'd0, blk[i][7:0]);
  endtask

  task automatic run_wait(input bit disturb);
    int d, n;
    bus_write(2'd2, 8'd1);
    bus_read(2'd3, d);
    chk("R4 status busy after start", d, 0);
    n = 1;
    if (disturb) begin
      bus_write(2'd0, 8'h55);          // R9 push while busy
      bus_write(2'd2, 8'd1);           // R9 command while busy
      bus_read(2'd1, d);
      chk("R9 pop while busy", d, 0);
      n = 4;
    end
    d = 0;
    while (d == 0 && n < 2000) begin
      bus_read(2'd3, d);
      n++;
    end
    chk("R4 status ready", d, 1);
    chk("R4 ready poll in window", int'(n >= 1024 && n <= 1028), 1);
  endtask

  task automatic pop_check(input string req, input int cnt);
    int d;
    for (int i = 0; i < cnt; i++) begin
      bus_read(2'd1, d);
      chk(req, d, exp_o[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int d;
    for (int u = 0; u < 8; u++)
      for (int x = 0; x < 8; x++)
        cf[u][x] = (u == 0) ? rnd(64.0 * $sqrt(0.125))
                            : rnd(32.0 * $cos((2.0*x + 1.0) * u * 3.14159265358979 / 16.0));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // reset state, R1 R4
    bus_read(2'd3, d); chk("R4 reset status", d, 1);
    bus_read(2'd0, d); chk("R1 data-in reads 0", d, 0);
    bus_read(2'd2, d); chk("R1 command reads 0", d, 0);

    // R5: impulse exposes coefficient products
    for (int i = 0; i < 64; i++) blk[i] = 0;
    blk[0] = 64;
    model(); load_block(); run_wait(0);
    pop_check("R5 impulse block", 64);

    // R6 R8: ramp block
    for (int i = 0; i < 64; i++) blk[i] = ((i * 37) % 256) - 128;
    model(); load_block(); run_wait(0);
    pop_check("R6 ramp block", 64);
    bus_read(2'd1, d); chk("R8 pop wraps to index 0", d, exp_o[0]);

    // R7: positive and negative saturation
    for (int i = 0; i < 64; i++) blk[i] = 127;
    model(); load_block(); run_wait(0);
    pop_check("R7 flat max", 64);
    for (int i = 0; i < 64; i++) blk[i] = -128;
    model(); load_block(); run_wait(0);
    pop_check("R7 flat min", 64);

    // R9 then R10: checkerboard, disturbed while busy, then rerun
    for (int i = 0; i < 64; i++) blk[i] = (((i >> 3) + i) & 1) ? 100 : -100;
    model(); load_block(); run_wait(1);
    pop_check("R9 results after busy accesses", 64);
    run_wait(0);
    pop_check("R10 rerun without reload", 64);

    // R3: other command value ignored, pop index kept
    run_wait(0);
    pop_check("R3 first pops", 10);
    bus_write(2'd2, 8'd2);
    bus_read(2'd3, d); chk("R3 command 2 leaves status idle", d, 1);
    bus_read(2'd1, d); chk("R3 pop index kept", d, exp_o[10]);

    // R2: 65th push overwrites sample 0
    for (int i = 0; i < 64; i++) blk[i] = (i % 8) * 20 - 70;
    load_block();
    bus_write(2'd0, 8'd90);
    blk[0] = 90;
    model(); run_wait(0);
    pop_check("R2 push wrap", 64);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule